// File: doc/BRIEF.md
# Paged MDIO Register Access Sequencer

This block sits between a host that wants to read or write 32-bit or 16-bit registers in a switch, and an MDIO master that can only move one 16-bit word per transaction. The switch reaches its large register space through a small window of PHY addresses plus a page register. The sequencer cuts each host byte address into a page, a PHY index and a register number. When the page differs from the one last programmed, it writes the page register and then waits a long settle time. After that it issues the one or two 16-bit data transactions the access needs.

The host presents one request at a time and sees `busy` until the whole series is done. It then gets a one-cycle response carrying the assembled read data and an error flag. A 32-bit write can send its low half or its high half first, under control of a per-request bit. A 16-bit access picks either half of the 32-bit register.

Top module: `paged_mdio_seq`

## Requirements
- R1: The effective address is split into three fields: the page is bits [17:9] (9 bits), the PHY index is bits [8:6], and the register number is bits [5:1]. Every data transaction targets PHY address 0x10 OR the PHY index.
- R2: After reset no page is cached. An access whose page differs from the cached page, or that arrives with no page cached, first writes the page value (zero-extended to 16 bits) to PHY 0x18, register 0, and then caches that page. An access whose page matches the cache issues no page write.
- R3: After the page write is acknowledged, `md_req` stays low for exactly SETTLE_CYC clock cycles before the first data transaction.
- R4: A 32-bit read (`req_is32`=1, `req_write`=0) reads register r and then register (r+1) mod 32. It returns {second word, first word} in `rsp_rdata`.
- R5: In a 32-bit write with `req_lo_first`=1, `req_wdata[15:0]` goes to r and then `req_wdata[31:16]` goes to r+1. With `req_lo_first`=0, the high half goes to r+1 first and the low half goes to r second. A write returns `rsp_rdata`=0.
- R6: A 16-bit access (`req_is32`=0) makes exactly one data transaction. With `req_hi_half`=0 it uses `req_addr` and writes `req_wdata[15:0]`, and a read returns {16'h0, word}. With `req_hi_half`=1 it uses `req_addr`+2, with carry into the upper fields, and writes `req_wdata[31:16]`, and a read returns {word, 16'h0}.
- R7: `rsp_err` is the OR of `md_err` over every transaction of the access, the page write included.
- R8: `req_ready` is low while `busy` is high. A `req_valid` raised while busy is ignored: it causes no transaction and no response.
- R9: Once raised, `md_req` holds with stable `md_phy`, `md_reg`, `md_write` and `md_wdata` until `md_ack`. Each accepted request yields exactly one single-cycle `rsp_valid` pulse.
- R10: After reset, `busy`, `md_req` and `rsp_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_is32 | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| req_hi_half | input | 1 | For 16-bit access, select the upper half |
| req_lo_first | input | 1 | For 32-bit writes, send the low half first |
| req_addr | input | 18 | Byte address in the switch register space |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | A sequence is in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Assembled read data |
| rsp_err | output | 1 | OR of transaction errors |
| md_req | output | 1 | Transaction request to MDIO master |
| md_write | output | 1 | Transaction direction, 1 = write |
| md_phy | output | 5 | Target PHY address |
| md_reg | output | 5 | Target register number |
| md_wdata | output | 16 | Write word |
| md_ack | input | 1 | Transaction done; read word and error valid |
| md_rdata | input | 16 | Read word |
| md_err | input | 1 | Transaction error |

## Verification
A request is taken at the clock edge after it is driven. The first MDIO request appears in the very next cycle, and each later request follows the previous acknowledge by one cycle, or by SETTLE_CYC cycles after a page write. The response pulse comes one cycle after the final acknowledge. The bench samples on falling edges. Its MDIO responder logs each transaction in the cycle it acknowledges, and it counts the low `md_req` cycles after a page-write acknowledge to measure the settle gap exactly. The bench collects responses through a monitor that counts pulses, not through a fixed wait. After each access it waits two further cycles to confirm that no extra transaction or pulse appeared.

// File: rtl/pmdio_pkg.sv
package pmdio_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_PAGE   = 2'd1,
      ST_SETTLE = 2'd2,
      ST_XFER   = 2'd3
   } seq_state_e;

   localparam int unsigned HALF_W = 16;
   localparam int unsigned WORD_W = 2 * HALF_W;

endpackage

// File: rtl/pmdio_addr_split.sv
module pmdio_addr_split #(
   parameter int unsigned ADDR_W   = 18,
   parameter int unsigned PAGE_LSB = 9,
   parameter int unsigned PAGE_W   = 9,
   parameter int unsigned IDX_LSB  = 6,
   parameter int unsigned IDX_W    = 3,
   parameter int unsigned REG_LSB  = 1,
   parameter int unsigned REG_W    = 5
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              is32_i,
   input  logic              hi_i,
   output logic [PAGE_W-1:0] page_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic [REG_W-1:0]  reg_o
);

   localparam int unsigned PAD_W = ADDR_W - 2;

   if (ADDR_W < PAGE_LSB + PAGE_W) begin : g_bad_page
      $error("address too narrow for page field");
   end
   if (IDX_LSB + IDX_W > PAGE_LSB) begin : g_bad_idx
      $error("index field overlaps page field");
   end
   if (REG_LSB + REG_W > IDX_LSB) begin : g_bad_reg
      $error("register field overlaps index field");
   end

   logic [ADDR_W-1:0] eff;

   // upper-half 16-bit access lands one half-word further on
   assign eff    = addr_i + {{PAD_W{1'b0}}, hi_i & ~is32_i, 1'b0};
   assign page_o = eff[PAGE_LSB +: PAGE_W];
   assign idx_o  = eff[IDX_LSB  +: IDX_W];
   assign reg_o  = eff[REG_LSB  +: REG_W];

endmodule

// File: rtl/pmdio_page_cache.sv
module pmdio_page_cache #(
   parameter int unsigned PAGE_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              update_i,
   input  logic [PAGE_W-1:0] page_i,
   input  logic [PAGE_W-1:0] lookup_i,
   output logic              hit_o,
   output logic              valid_o,
   output logic [PAGE_W-1:0] page_o
);

   logic              valid_q;
   logic [PAGE_W-1:0] page_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         page_q  <= '0;
      end else if (update_i) begin
         valid_q <= 1'b1;
         page_q  <= page_i;
      end
   end

   assign hit_o   = valid_q && (page_q == lookup_i);
   assign valid_o = valid_q;
   assign page_o  = page_q;

   // R2: a page write leaves exactly that page cached
   p_cache_takes_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
      update_i |=> (valid_q && page_q == $past(page_i)));

endmodule

// File: rtl/pmdio_settle_timer.sv
module pmdio_settle_timer #(
   parameter int unsigned CYCLES = 200000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic running_o,
   output logic last_o
);

   localparam int unsigned CNT_W = $clog2(CYCLES + 1);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("settle time must be at least one cycle");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start_i) begin
         cnt_q <= CNT_W'(CYCLES);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign running_o = (cnt_q != '0);
   assign last_o    = (cnt_q == CNT_W'(1));

   // R3: the count falls by one every cycle until it is spent
   p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (running_o && !start_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/paged_mdio_seq.sv
module paged_mdio_seq
   import pmdio_pkg::*;
#(
   parameter int unsigned          ADDR_W     = 18,
   parameter int unsigned          PAGE_LSB   = 9,
   parameter int unsigned          PAGE_W     = 9,
   parameter int unsigned          IDX_LSB    = 6,
   parameter int unsigned          IDX_W      = 3,
   parameter int unsigned          REG_LSB    = 1,
   parameter int unsigned          REG_W      = 5,
   parameter int unsigned          PHYA_W     = 5,
   parameter logic [PHYA_W-1:0]    PAGE_PHY   = 5'h18,
   parameter logic [REG_W-1:0]     PAGE_REG   = '0,
   parameter logic [PHYA_W-1:0]    DATA_PHY   = 5'h10,
   parameter int unsigned          SETTLE_CYC = 200000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_write,
   input  logic                req_is32,
   input  logic                req_hi_half,
   input  logic                req_lo_first,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [WORD_W-1:0]   req_wdata,
   output logic                busy,
   output logic                rsp_valid,
   output logic [WORD_W-1:0]   rsp_rdata,
   output logic                rsp_err,
   output logic                md_req,
   output logic                md_write,
   output logic [PHYA_W-1:0]   md_phy,
   output logic [REG_W-1:0]    md_reg,
   output logic [HALF_W-1:0]   md_wdata,
   input  logic                md_ack,
   input  logic [HALF_W-1:0]   md_rdata,
   input  logic                md_err
);

   localparam int unsigned PAGE_PAD = HALF_W - PAGE_W;
   localparam int unsigned IDX_PAD  = PHYA_W - IDX_W;

   if (PAGE_W > HALF_W) begin : g_bad_pagew
      $error("page value does not fit one MDIO word");
   end
   if (IDX_W > PHYA_W) begin : g_bad_idxw
      $error("PHY index wider than PHY address");
   end

   // request decode on the live host inputs
   logic [PAGE_W-1:0] in_page;
   logic [IDX_W-1:0]  in_idx;
   logic [REG_W-1:0]  in_reg;

   pmdio_addr_split #(
      .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .PAGE_W(PAGE_W),
      .IDX_LSB(IDX_LSB), .IDX_W(IDX_W), .REG_LSB(REG_LSB), .REG_W(REG_W)
   ) u_split (
      .addr_i (req_addr),
      .is32_i (req_is32),
      .hi_i   (req_hi_half),
      .page_o (in_page),
      .idx_o  (in_idx),
      .reg_o  (in_reg)
   );

   seq_state_e        state_q;
   logic [PAGE_W-1:0] page_q;
   logic [IDX_W-1:0]  idx_q;
   logic [REG_W-1:0]  reg_q;
   logic              write_q, is32_q, hi_q, lofirst_q, step_q, err_q;
   logic [WORD_W-1:0] wdata_q;
   logic [HALF_W-1:0] acc_lo_q, acc_hi_q;

   logic              accept, cache_hit, cache_valid, cache_upd;
   logic [PAGE_W-1:0] cache_page;
   logic              settle_start, settle_run, settle_last;

   assign req_ready    = (state_q == ST_IDLE);
   assign busy         = ~req_ready;
   assign accept       = req_valid && req_ready;
   assign cache_upd    = (state_q == ST_PAGE) && md_ack;
   assign settle_start = cache_upd;

   pmdio_page_cache #(.PAGE_W(PAGE_W)) u_cache (
      .clk      (clk),
      .rst_n    (rst_n),
      .update_i (cache_upd),
      .page_i   (page_q),
      .lookup_i (in_page),
      .hit_o    (cache_hit),
      .valid_o  (cache_valid),
      .page_o   (cache_page)
   );

   pmdio_settle_timer #(.CYCLES(SETTLE_CYC)) u_settle (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (settle_start),
      .running_o (settle_run),
      .last_o    (settle_last)
   );

   // which register offset and which half the current step moves
   logic step_off, step_hi, step_last;

   always_comb begin
      if (!is32_q) begin
         step_off  = 1'b0;
         step_hi   = hi_q;
         step_last = 1'b1;
      end else if (!write_q || lofirst_q) begin
         step_off  = step_q;
         step_hi   = step_q;
         step_last = step_q;
      end else begin
         step_off  = ~step_q;
         step_hi   = ~step_q;
         step_last = step_q;
      end
   end

   always_comb begin
      md_req = (state_q == ST_PAGE) || (state_q == ST_XFER);
      if (state_q == ST_PAGE) begin
         md_write = 1'b1;
         md_phy   = PAGE_PHY;
         md_reg   = PAGE_REG;
         md_wdata = {{PAGE_PAD{1'b0}}, page_q};
      end else begin
         md_write = write_q;
         md_phy   = DATA_PHY | {{IDX_PAD{1'b0}}, idx_q};
         md_reg   = reg_q + {{(REG_W-1){1'b0}}, step_off};
         md_wdata = step_hi ? wdata_q[WORD_W-1:HALF_W] : wdata_q[HALF_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         page_q    <= '0;
         idx_q     <= '0;
         reg_q     <= '0;
         write_q   <= 1'b0;
         is32_q    <= 1'b0;
         hi_q      <= 1'b0;
         lofirst_q <= 1'b0;
         step_q    <= 1'b0;
         err_q     <= 1'b0;
         wdata_q   <= '0;
         acc_lo_q  <= '0;
         acc_hi_q  <= '0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  page_q    <= in_page;
                  idx_q     <= in_idx;
                  reg_q     <= in_reg;
                  write_q   <= req_write;
                  is32_q    <= req_is32;
                  hi_q      <= req_hi_half;
                  lofirst_q <= req_lo_first;
                  wdata_q   <= req_wdata;
                  step_q    <= 1'b0;
                  err_q     <= 1'b0;
                  acc_lo_q  <= '0;
                  acc_hi_q  <= '0;
                  state_q   <= cache_hit ? ST_XFER : ST_PAGE;
               end
            end
            ST_PAGE: begin
               if (md_ack) begin
                  err_q   <= err_q | md_err;
                  state_q <= ST_SETTLE;
               end
            end
            ST_SETTLE: begin
               if (settle_last) begin
                  state_q <= ST_XFER;
               end
            end
            ST_XFER: begin
               if (md_ack) begin
                  err_q <= err_q | md_err;
                  if (step_hi) acc_hi_q <= md_rdata;
                  else         acc_lo_q <= md_rdata;
                  if (step_last) begin
                     state_q   <= ST_IDLE;
                     rsp_valid <= 1'b1;
                     rsp_err   <= err_q | md_err;
                     rsp_rdata <= write_q ? '0 :
                                  {step_hi ? md_rdata : acc_hi_q,
                                   step_hi ? acc_lo_q : md_rdata};
                  end else begin
                     step_q <= 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R9: a pending transaction keeps its fields until acknowledged
   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (md_req && !md_ack) |=> (md_req && $stable(md_phy) && $stable(md_reg)
                               && $stable(md_write) && $stable(md_wdata)));

   // R9: completion is a single-cycle pulse
   p_single_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R3: the bus is quiet while the page settles
   p_quiet_settle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      settle_run |-> !md_req);

   // R2: data transactions only run with their own page programmed
   p_page_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_XFER) |-> (cache_valid && cache_page == page_q));

   // R8: a request while busy leaves the captured access untouched
   p_refuse_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && busy) |=> ($stable(page_q) && $stable(reg_q)
                               && $stable(idx_q) && $stable(wdata_q)));

endmodule

// File: tb/paged_mdio_seq_bench.sv
module paged_mdio_seq_bench;

   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_is32 = 1'b0;
   logic        req_hi_half = 1'b0, req_lo_first = 1'b0;
   logic [17:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ready, busy, rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;
   logic        md_req, md_write;
   logic [4:0]  md_phy, md_reg;
   logic [15:0] md_wdata;
   logic        md_ack = 1'b0, md_err = 1'b0;
   logic [15:0] md_rdata = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   paged_mdio_seq #(.SETTLE_CYC(SETTLE)) u_paged_mdio_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_is32(req_is32), .req_hi_half(req_hi_half),
      .req_lo_first(req_lo_first), .req_addr(req_addr), .req_wdata(req_wdata),
      .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
      .md_req(md_req), .md_write(md_write), .md_phy(md_phy), .md_reg(md_reg),
      .md_wdata(md_wdata), .md_ack(md_ack), .md_rdata(md_rdata), .md_err(md_err)
   );

   int checks = 0, fails = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // MDIO responder and monitors
   logic [4:0]  log_phy [0:7];
   logic [4:0]  log_reg [0:7];
   logic        log_wr  [0:7];
   logic [15:0] log_wd  [0:7];
   logic [15:0] log_rd  [0:7];
   logic        log_er  [0:7];
   int          log_n = 0;
   int          lat = 0;
   bit          measuring = 1'b0;
   int          gap_cnt = 0, gap = -1;
   int          rsp_cnt = 0;
   logic [31:0] got_rdata = '0;
   logic        got_err = 1'b0;

   always @(negedge clk) begin
      if (measuring) begin
         if (md_req) begin gap = gap_cnt; measuring = 1'b0; end
         else gap_cnt++;
      end
      if (rsp_valid) begin
         rsp_cnt++;
         got_rdata = rsp_rdata;
         got_err   = rsp_err;
      end
      if (md_ack) begin
         md_ack = 1'b0;
         md_err = 1'b0;
      end else if (md_req) begin
         if (lat == 0) begin
            md_ack   = 1'b1;
            md_rdata = 16'($urandom);
            md_err   = ($urandom % 6) == 0;
            if (log_n < 8) begin
               log_phy[log_n] = md_phy;
               log_reg[log_n] = md_reg;
               log_wr[log_n]  = md_write;
               log_wd[log_n]  = md_wdata;
               log_rd[log_n]  = md_rdata;
               log_er[log_n]  = md_err;
            end
            log_n++;
            if (md_phy == 5'h18) begin measuring = 1'b1; gap_cnt = 0; end
            lat = $urandom % 3;
         end else begin
            lat--;
         end
      end
   end

   // bench reference of the page cache
   bit         m_valid = 1'b0;
   logic [8:0] m_page = '0;

   task automatic do_access(input bit wr, input logic [17:0] addr, input logic [31:0] wd,
                            input bit is32, input bit hi, input bit lof, input bit spur);
      logic [17:0] eff;
      logic [8:0]  pg;
      logic [2:0]  idx;
      logic [4:0]  rg;
      bit          miss;
      int          n_exp, base, guard;
      logic [4:0]  e_reg [0:2];
      logic [15:0] e_wd  [0:2];
      logic [31:0] e_rd;
      logic        e_err;
      eff  = is32 ? addr : addr + (hi ? 18'd2 : 18'd0);
      pg   = eff[17:9];
      idx  = eff[8:6];
      rg   = eff[5:1];
      miss = !m_valid || (m_page != pg);
      m_valid = 1'b1;
      m_page  = pg;
      base = miss ? 1 : 0;
      // R4 / R5 / R6 expected order
      if (is32 && (!wr || lof)) begin
         e_reg[base] = rg;        e_wd[base] = wd[15:0];
         e_reg[base+1] = rg + 5'd1; e_wd[base+1] = wd[31:16];
      end else if (is32) begin
         e_reg[base] = rg + 5'd1; e_wd[base] = wd[31:16];
         e_reg[base+1] = rg;      e_wd[base+1] = wd[15:0];
      end else begin
         e_reg[base] = rg;        e_wd[base] = hi ? wd[31:16] : wd[15:0];
      end
      n_exp = base + (is32 ? 2 : 1);

      log_n = 0; gap = -1; rsp_cnt = 0; measuring = 1'b0;
      guard = 0;
      while (!req_ready && guard < 500) begin @(negedge clk); guard++; end
      req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
      req_is32 = is32; req_hi_half = hi; req_lo_first = lof;
      @(negedge clk);
      if (spur) begin
         req_addr = ~addr; req_wdata = ~wd; req_write = ~wr;
         chk(req_ready == 1'b0, "R8 ready low while busy", req_ready, 0);
         @(negedge clk);
      end
      req_valid = 1'b0;
      guard = 0;
      while (rsp_cnt == 0 && guard < 4 * SETTLE + 200) begin @(negedge clk); guard++; end
      chk(rsp_cnt > 0, "R9 response arrived", rsp_cnt, 1);
      @(negedge clk); @(negedge clk);
      chk(rsp_cnt == 1, "R9 one response pulse", rsp_cnt, 1);
      chk(log_n == n_exp, "R8 transaction count", log_n, n_exp);
      if (miss && log_n > 0) begin
         chk(log_phy[0] == 5'h18 && log_reg[0] == 5'd0 && log_wr[0],
             "R2 page write target", {log_phy[0], log_reg[0]}, {5'h18, 5'd0});
         chk(log_wd[0] == {7'd0, pg}, "R2 page value", log_wd[0], {7'd0, pg});
         chk(gap == SETTLE, "R3 settle gap", gap, SETTLE);
      end
      for (int k = base; k < n_exp && k < log_n; k++) begin
         chk(log_phy[k] == (5'h10 | {2'b00, idx}), "R1 data PHY", log_phy[k], 5'h10 | {2'b00, idx});
         chk(log_reg[k] == e_reg[k], is32 ? "R4 register order" : "R6 register", log_reg[k], e_reg[k]);
         chk(log_wr[k] == wr, "R1 direction", log_wr[k], wr);
         if (wr) chk(log_wd[k] == e_wd[k], is32 ? "R5 write half" : "R6 write half", log_wd[k], e_wd[k]);
      end
      if (log_n == n_exp) begin
         if (wr) e_rd = 32'h0;
         else if (is32) e_rd = {log_rd[base+1], log_rd[base]};
         else if (hi) e_rd = {log_rd[base], 16'h0};
         else e_rd = {16'h0, log_rd[base]};
         chk(got_rdata == e_rd, is32 ? "R4 read data" : "R6 read data", got_rdata, e_rd);
         e_err = 1'b0;
         for (int k = 0; k < log_n; k++) e_err = e_err | log_er[k];
         chk(got_err == e_err, "R7 error OR", got_err, e_err);
      end
   endtask

   function automatic logic [17:0] mk_addr(input logic [8:0] pg, input logic [2:0] idx,
                                          input logic [4:0] rg);
      return {pg, idx, rg, 1'b0};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0A11));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(busy == 1'b0 && req_ready == 1'b1, "R10 idle after reset", {busy, req_ready}, 2'b01);
      chk(md_req == 1'b0 && rsp_valid == 1'b0, "R10 outputs quiet", {md_req, rsp_valid}, 0);

      // R2: first access misses, second on same page hits
      do_access(0, mk_addr(9'd3, 3'd2, 5'd4), 32'h0, 1, 0, 0, 0);
      do_access(1, mk_addr(9'd3, 3'd5, 5'd6), 32'hCAFE_1234, 1, 0, 1, 0);
      // R5 high half first
      do_access(1, mk_addr(9'd3, 3'd1, 5'd8), 32'hA5A5_5A5A, 1, 0, 0, 0);
      // R6 both halves, read and write
      do_access(0, mk_addr(9'd3, 3'd0, 5'd2), 32'h0, 0, 0, 0, 0);
      do_access(0, mk_addr(9'd3, 3'd0, 5'd2), 32'h0, 0, 1, 0, 0);
      do_access(1, mk_addr(9'd3, 3'd4, 5'd10), 32'h1111_2222, 0, 1, 0, 0);
      // R6 upper half carries across PHY index and page
      do_access(0, mk_addr(9'd5, 3'd7, 5'd31), 32'h0, 0, 1, 0, 0);
      // R4 register number wraps within 5 bits
      do_access(0, mk_addr(9'd6, 3'd2, 5'd31), 32'h0, 1, 0, 0, 0);
      // R8 request while busy is refused
      do_access(1, mk_addr(9'd6, 3'd3, 5'd0), 32'h7777_8888, 1, 0, 1, 1);
      do_access(0, mk_addr(9'd7, 3'd3, 5'd0), 32'h0, 0, 0, 0, 1);

      for (int i = 0; i < 40; i++) begin
         logic [17:0] a;
         a = mk_addr(9'($urandom % 3), 3'($urandom), 5'($urandom));
         do_access(1'($urandom), a, $urandom, 1'($urandom), 1'($urandom),
                   1'($urandom), ($urandom % 4) == 0);
      end

      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule